// File: doc/BRIEF.md
# Look-Through Read Cache Controller

This block sits in series between a processor-side read port and a shared system bus. Every processor read is first compared against a small direct-mapped tag store. When the line is present and its tag matches, the word comes straight out of the local data store and the system bus is never touched. When the line is absent, the controller requests ownership of the system bus. Once granted, it forwards the read, waits for memory, writes the returned word into the line and hands the same word to the processor.

The processor port is fully decoupled from the system bus. While another master holds the system bus, reads that hit still complete at full speed. The price is that a miss only reaches the system bus after the lookup cycle has finished. Only one read is in flight at a time. Each line holds a single word, and the byte-offset bits of the address play no part in the lookup.

Top module: `lt_read_cache`

## Requirements
- R1: After reset all lines are invalid and the ports read cpu_req_ready=1, cpu_rsp_valid=0, sys_bus_req=0 and sys_rd_valid=0. The first read of any address after reset is a miss.
- R2: A read that hits raises cpu_rsp_valid for exactly one cycle, one rising edge after the acceptance edge. cpu_rsp_data carries the stored word.
- R3: During a hitting read, sys_bus_req and sys_rd_valid stay low from acceptance until the response.
- R4: On a miss, sys_bus_req rises after the lookup cycle. sys_rd_valid is asserted only while sys_bus_gnt is high, and the address is held stable until sys_rd_ready.
- R5: On a miss, sys_rd_addr equals the processor address unchanged.
- R6: On a miss, the word returned on sys_rsp_data goes to cpu_rsp_data and is stored in the line, so a repeat read of that word hits.
- R7: The miss response appears 3 + W + M rising edges after the acceptance edge. W is the number of cycles in which sys_bus_req is high and sys_bus_gnt is low. M is the number of edges from the system-side address acceptance to the edge that samples sys_rsp_valid.
- R8: Address bits [1:0] are ignored, so any byte address within a stored word hits.
- R9: The line index is address bits [5:2] and the tag is bits [31:6]. A read with the same index and a different tag misses and replaces the line.
- R10: cpu_req_ready is low from the acceptance edge until the cycle in which the response is presented, so only one read is outstanding.
- R11: Withholding sys_bus_gnt has no effect on hits, which keep the latency of R2.
- R12: On a miss, sys_bus_req stays high continuously until the edge that samples sys_rsp_valid, and is low in the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor read request valid |
| cpu_req_ready | output | 1 | Controller can accept a read |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| cpu_rsp_data | output | 32 | Read data to processor |
| sys_bus_req | output | 1 | System bus ownership request |
| sys_bus_gnt | input | 1 | System bus ownership grant |
| sys_rd_valid | output | 1 | System read address valid |
| sys_rd_ready | input | 1 | Memory accepts the read address |
| sys_rd_addr | output | 32 | System read address |
| sys_rsp_valid | input | 1 | Memory read data valid |
| sys_rsp_data | input | 32 | Memory read data |

## Verification
A valid bit or tag that is wrong internally shows up at the ports within the next read of that line. A stale line turns an expected miss into a one-edge hit with no system-bus request. A lost fill turns an expected hit into a request on sys_bus_req one cycle after acceptance. A corrupted data word shows in the same response cycle as a mismatch on cpu_rsp_data. A controller stuck in a state shows within a cycle or two as cpu_req_ready staying low, or as sys_bus_req dropping or lingering against the latency rule.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_ARB,
      ST_ISSUE,
      ST_WAIT
   } ltc_state_e;
endpackage

// File: rtl/ltc_tag_store.sv
module ltc_tag_store #(
   parameter int LINES = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
      end
   end

   assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

   // R6: a fill leaves the written line valid with the written tag
   p_fill_sets_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));
endmodule

// File: rtl/ltc_data_store.sv
module ltc_data_store #(
   parameter int LINES          = 16,
   parameter int IDX_W          = 4,
   parameter int DATA_W         = 32,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);
   logic [DATA_W-1:0] data_q [LINES];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < LINES; i++) data_q[i] <= '0;
            end else if (wr_en) begin
               data_q[wr_idx] <= wr_data;
            end
         end
      end else begin : g_plain
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (wr_en) data_q[wr_idx] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/ltc_ctrl.sv
module ltc_ctrl
   import ltc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   parameter int OFF_W  = 2,
   parameter int TAG_W  = 26
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_data,
   output logic [IDX_W-1:0]  line_idx,
   output logic [TAG_W-1:0]  line_tag,
   input  logic              hit,
   input  logic [DATA_W-1:0] hit_data,
   output logic              fill_en,
   output logic              sys_bus_req,
   input  logic              sys_bus_gnt,
   output logic              sys_rd_valid,
   input  logic              sys_rd_ready,
   output logic [ADDR_W-1:0] sys_rd_addr,
   input  logic              sys_rsp_valid,
   input  logic [DATA_W-1:0] sys_rsp_data
);
   ltc_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         addr_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (cpu_req_valid) begin
               addr_q  <= cpu_req_addr;
               state_q <= ST_LOOKUP;
            end
            ST_LOOKUP: if (hit) begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= hit_data;
               state_q     <= ST_IDLE;
            end else begin
               state_q <= ST_ARB;
            end
            ST_ARB:   if (sys_bus_gnt)  state_q <= ST_ISSUE;
            ST_ISSUE: if (sys_rd_ready) state_q <= ST_WAIT;
            ST_WAIT: if (sys_rsp_valid) begin
               rsp_valid_q <= 1'b1;
               rsp_data_q  <= sys_rsp_data;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cpu_req_ready = (state_q == ST_IDLE);
   assign cpu_rsp_valid = rsp_valid_q;
   assign cpu_rsp_data  = rsp_data_q;
   assign line_idx      = addr_q[OFF_W +: IDX_W];
   assign line_tag      = addr_q[ADDR_W-1 -: TAG_W];
   assign fill_en       = (state_q == ST_WAIT) && sys_rsp_valid;
   assign sys_bus_req   = (state_q == ST_ARB) || (state_q == ST_ISSUE) || (state_q == ST_WAIT);
   assign sys_rd_valid  = (state_q == ST_ISSUE);
   assign sys_rd_addr   = addr_q;

   // R10: an accepted read blocks the next one
   p_accept_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);
   // R2: the response is a single-cycle pulse
   p_rsp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |=> !cpu_rsp_valid);
   // R3: a hit never requests the system bus
   p_hit_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOKUP && hit) |=> !sys_bus_req);
   // R4: system read only while granted, held until accepted
   p_rd_under_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rd_valid |-> sys_bus_gnt);
   p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_rd_valid && !sys_rd_ready) |=> (sys_rd_valid && $stable(sys_rd_addr)));
   // R12: bus request held until memory data returns
   p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_bus_req && !sys_rsp_valid) |=> sys_bus_req);
   p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (!sys_bus_req && cpu_rsp_valid));
endmodule

// File: rtl/lt_read_cache.sv
module lt_read_cache #(
   parameter int ADDR_W         = 32,
   parameter int DATA_W         = 32,
   parameter int LINES          = 16,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   output logic              cpu_req_ready,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_rsp_valid,
   output logic [DATA_W-1:0] cpu_rsp_data,
   output logic              sys_bus_req,
   input  logic              sys_bus_gnt,
   output logic              sys_rd_valid,
   input  logic              sys_rd_ready,
   output logic [ADDR_W-1:0] sys_rd_addr,
   input  logic              sys_rsp_valid,
   input  logic [DATA_W-1:0] sys_rsp_data
);
   localparam int IDX_W = $clog2(LINES);
   localparam int OFF_W = $clog2(DATA_W / 8);
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("DATA_W must be a power of two of at least 16");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("ADDR_W too narrow for LINES and DATA_W");
      end
   endgenerate

   logic [IDX_W-1:0]  line_idx;
   logic [TAG_W-1:0]  line_tag;
   logic              hit;
   logic [DATA_W-1:0] hit_data;
   logic              fill_en;

   ltc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_addr(cpu_req_addr),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
      .line_idx(line_idx), .line_tag(line_tag),
      .hit(hit), .hit_data(hit_data), .fill_en(fill_en),
      .sys_bus_req(sys_bus_req), .sys_bus_gnt(sys_bus_gnt),
      .sys_rd_valid(sys_rd_valid), .sys_rd_ready(sys_rd_ready),
      .sys_rd_addr(sys_rd_addr),
      .sys_rsp_valid(sys_rsp_valid), .sys_rsp_data(sys_rsp_data)
   );

   ltc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(line_idx), .rd_tag(line_tag), .hit(hit),
      .wr_en(fill_en), .wr_idx(line_idx), .wr_tag(line_tag)
   );

   ltc_data_store #(
      .LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) i_data (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(line_idx), .rd_data(hit_data),
      .wr_en(fill_en), .wr_idx(line_idx), .wr_data(sys_rsp_data)
   );
endmodule

// File: tb/test_lt_read_cache.sv
`timescale 1ns/1ps
module test_lt_read_cache;
   localparam int MEM_LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req_valid = 1'b0;
   logic        cpu_req_ready;
   logic [31:0] cpu_req_addr = '0;
   logic        cpu_rsp_valid;
   logic [31:0] cpu_rsp_data;
   logic        sys_bus_req;
   logic        sys_bus_gnt = 1'b0;
   logic        sys_rd_valid;
   logic        sys_rd_ready;
   logic [31:0] sys_rd_addr;
   logic        sys_rsp_valid = 1'b0;
   logic [31:0] sys_rsp_data = '0;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int other_until = 0;

   // reference cache contents
   bit          ref_valid [16];
   logic [25:0] ref_tag   [16];
   logic [31:0] ref_data  [16];

   always #2.5 clk = ~clk;

   lt_read_cache i_lt_read_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
      .cpu_req_addr(cpu_req_addr),
      .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_data(cpu_rsp_data),
      .sys_bus_req(sys_bus_req), .sys_bus_gnt(sys_bus_gnt),
      .sys_rd_valid(sys_rd_valid), .sys_rd_ready(sys_rd_ready),
      .sys_rd_addr(sys_rd_addr),
      .sys_rsp_valid(sys_rsp_valid), .sys_rsp_data(sys_rsp_data)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return {w[15:0], w[31:16]} ^ 32'hC0DE_5A11;
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // competing master: grant withheld until other_until
   always @(posedge clk) begin
      if (!rst_n) sys_bus_gnt <= 1'b0;
      else        sys_bus_gnt <= sys_bus_req && (cyc >= other_until);
   end

   // behavioural memory
   assign sys_rd_ready = 1'b1;
   bit          mem_busy = 1'b0;
   int          mem_cnt  = 0;
   logic [31:0] mem_addr = '0;
   logic [31:0] last_sys_addr = '0;
   always @(posedge clk) begin
      sys_rsp_valid <= 1'b0;
      if (!rst_n) begin
         mem_busy <= 1'b0;
      end else if (mem_busy) begin
         if (mem_cnt == 1) begin
            sys_rsp_valid <= 1'b1;
            sys_rsp_data  <= mem_word(mem_addr);
            mem_busy      <= 1'b0;
         end else begin
            mem_cnt <= mem_cnt - 1;
         end
      end else if (sys_rd_valid && sys_rd_ready) begin
         mem_busy      <= 1'b1;
         mem_cnt       <= MEM_LAT;
         mem_addr      <= sys_rd_addr;
         last_sys_addr <= sys_rd_addr;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic check_idle_outputs(input string req);
      chk(cpu_req_ready == 1'b1, req, "cpu_req_ready", 32'(cpu_req_ready), 32'd1);
      chk(cpu_rsp_valid == 1'b0, req, "cpu_rsp_valid", 32'(cpu_rsp_valid), 32'd0);
      chk(sys_bus_req == 1'b0, req, "sys_bus_req", 32'(sys_bus_req), 32'd0);
      chk(sys_rd_valid == 1'b0, req, "sys_rd_valid", 32'(sys_rd_valid), 32'd0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cpu_req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) ref_valid[i] = 1'b0;
      @(negedge clk);
   endtask

   // one read; called at a negedge with cpu_req_ready high
   task automatic do_read(input logic [31:0] addr, input int other, input string tag_req);
      logic [3:0]  idx;
      logic [25:0] tg;
      bit          exp_hit;
      logic [31:0] exp_data;
      int          n, stall;
      bit          bus_on_hit, ready_hi, req_dropped, bus_seen, rd_seen;
      idx = addr[5:2];
      tg  = addr[31:6];
      exp_hit  = ref_valid[idx] && ref_tag[idx] == tg;
      exp_data = exp_hit ? ref_data[idx] : mem_word(addr);
      other_until = cyc + other;
      cpu_req_addr  = addr;
      cpu_req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 1'b0;
      n = 0; stall = 0;
      bus_on_hit = 0; ready_hi = 0; req_dropped = 0; bus_seen = 0; rd_seen = 0;
      while (!cpu_rsp_valid && n < 2000) begin
         if (cpu_req_ready) ready_hi = 1;
         if (exp_hit && (sys_bus_req || sys_rd_valid)) bus_on_hit = 1;
         if (sys_bus_req && !sys_bus_gnt) stall++;
         if (sys_bus_req) bus_seen = 1;
         else if (bus_seen) req_dropped = 1;
         if (sys_rd_valid) rd_seen = 1;
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      chk(n < 2000, tag_req, "watchdog: no response", 32'(n), 32'd0);
      chk(!ready_hi, "R10", "cpu_req_ready high while busy", 32'(ready_hi), 32'd0);
      chk(cpu_rsp_data == exp_data, exp_hit ? "R2" : "R6", {tag_req, " data"},
          cpu_rsp_data, exp_data);
      if (exp_hit) begin
         chk(n == 1, "R2", {tag_req, " hit latency"}, 32'(n), 32'd1);
         chk(!bus_on_hit, "R3", "system bus touched on hit", 32'(bus_on_hit), 32'd0);
      end else begin
         chk(n == 3 + stall + MEM_LAT + 1, "R7", {tag_req, " miss latency"},
             32'(n), 32'(3 + stall + MEM_LAT + 1));
         chk(rd_seen, "R4", "no system read on miss", 32'(rd_seen), 32'd1);
         chk(last_sys_addr == addr, "R5", "forwarded address", last_sys_addr, addr);
         chk(!req_dropped && !sys_bus_req, "R12", "bus request shape",
             32'({req_dropped, sys_bus_req}), 32'd0);
         ref_valid[idx] = 1'b1;
         ref_tag[idx]   = tg;
         ref_data[idx]  = exp_data;
      end
      chk(cpu_req_ready == 1'b1, "R10", "ready in response cycle", 32'(cpu_req_ready), 32'd1);
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) ref_valid[i] = 1'b0;
      do_reset();
      check_idle_outputs("R1");

      do_read(32'h0000_1000, 0, "R6");           // cold miss
      do_read(32'h0000_1000, 0, "R6");           // repeat hits
      do_read(32'h0000_1003, 0, "R8");           // byte offset ignored
      do_read(32'h0000_1001, 0, "R8");
      do_read(32'h0000_2000, 0, "R9");           // same index, new tag: miss
      do_read(32'h0000_1000, 0, "R9");           // replaced: miss again
      do_read(32'hABCD_0044, 6, "R7");           // grant withheld on miss
      do_read(32'hABCD_0044, 0, "R2");
      for (int i = 0; i < 16; i++) do_read(32'h0003_0000 + 32'(i * 4), i % 3, "R9");
      for (int i = 0; i < 16; i++) do_read(32'h0003_0002 + 32'(i * 4), 0, "R2");
      do_read(32'h0003_0010, 30, "R11");         // hit while competitor owns bus
      do_read(32'h0003_0020, 30, "R11");

      do_reset();
      check_idle_outputs("R1");
      do_read(32'h0003_0010, 0, "R1");           // previously cached: miss after reset
      do_read(32'h0003_0010, 0, "R2");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule